// File: doc/BRIEF.md
# Translation-First Three-Queue DRAM Request Arbiter

This block sits in front of a DRAM controller and picks one request per cycle from three internal queues. Page-walk (address translation) requests enter a short first-in first-out queue and are always served first, in the order they arrived. Data requests are sorted by application. Those from the application that currently holds the favoured turn go to a middle queue. All others go to a normal queue. Both data queues pick row-buffer hits before older requests, using a one-open-row-per-bank model that every issued request updates.

The favoured turn rotates among applications. Each application's share of the middle queue per turn comes from two per-application metrics gathered over an epoch: a 6-bit count of concurrent page walks and a 6-bit maximum of warps merged onto one outstanding miss. At each epoch boundary the block takes a snapshot of the product of the two metrics for every application and clears both metrics. A sequential divider then turns each product into a quota scaled by `QMAX`. An application whose quota is zero never receives the turn.

Top module: `tprio_dram_arb`

## Requirements
- R1: Translation requests leave in exact arrival order, even when a later one would be a row-buffer hit and an earlier one would not.
- R2: Priority is strict: a waiting translation request beats any data request, and a waiting favoured data request beats any normal data request, whatever their ages.
- R3: Within the favoured queue and within the normal queue, a request whose row equals the open row of its bank goes first; among hits, or when there is no hit, the oldest goes first. Every issued request, translation included, makes its row the open row of its bank.
- R4: `issue_cls` reports the source queue: 0 translation, 1 favoured, 2 normal. A data request goes to the favoured queue exactly when its application holds the turn and that application's quota is nonzero.
- R5: At each epoch end, app i gets quota floor(QMAX·P_i / ΣP_j), where P = walk count × merged-warp maximum. Once the holder has placed that many requests in the favoured queue, the turn moves to the next application in rising ID order (wrapping around) that has a nonzero quota.
- R6: An application whose quota is zero is skipped by the rotation. When every quota is zero, which is the case from reset until the first epoch yields a nonzero product, all data requests go to the normal queue.
- R7: The walk count rises on a walk start and falls on a walk end for its application, saturating at 0 and 63. The merged-warp metric keeps the largest value reported. Both are cleared at every epoch end, so an epoch with no reports yields zero quotas.
- R8: `xlat_ready` is low only while the translation queue is full. `data_ready` is low only while the queue that the presented data request would enter is full, so a full queue stalls only its own class.
- R9: After reset no request is offered, both ready outputs are high, and all quotas are zero.
- R10: While `issue_ready` is low, nothing is removed and `issue_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_valid | input | 1 | Translation request offered |
| xlat_app | input | 2 | Application of translation request |
| xlat_bank | input | 2 | Bank of translation request |
| xlat_row | input | 8 | Row of translation request |
| xlat_ready | output | 1 | Translation queue can accept |
| data_valid | input | 1 | Data request offered |
| data_app | input | 2 | Application of data request |
| data_bank | input | 2 | Bank of data request |
| data_row | input | 8 | Row of data request |
| data_ready | output | 1 | Target data queue can accept |
| walk_start_valid | input | 1 | A page walk started |
| walk_start_app | input | 2 | Application of started walk |
| walk_end_valid | input | 1 | A page walk finished |
| walk_end_app | input | 2 | Application of finished walk |
| merge_valid | input | 1 | Merged-warp count report |
| merge_app | input | 2 | Application of the report |
| merge_warps | input | 6 | Warps merged on one miss entry |
| issue_ready | input | 1 | Downstream takes the offered request |
| issue_valid | output | 1 | A request is offered |
| issue_cls | output | 2 | Source queue of the offered request |
| issue_app | output | 2 | Application of offered request |
| issue_bank | output | 2 | Bank of offered request |
| issue_row | output | 8 | Row of offered request |

## Verification
A request accepted at a rising edge shows up on the issue outputs right after that edge, because the queues are registers and the selection after them is combinational. The ready outputs follow the presented application and the queue counts at once. The checks therefore drive at a falling edge and read the issue outputs at the next falling edge, where a queued backlog produces exactly one new head per cycle. New quotas land one application at a time within NAPP·(QW+PW) cycles after an epoch boundary. The rotation and cleared-metric checks run only after the bench's cycle count has passed the boundary and that divider window, and they finish well before the next boundary.

// File: rtl/tprio_dram_arb.sv
module tprio_dram_arb #(
  parameter int NAPP      = 4,
  parameter int NBANK     = 4,
  parameter int ROWW      = 8,
  parameter int TQD       = 4,
  parameter int DQD       = 4,
  parameter int CNTW      = 6,
  parameter int QMAX      = 8,
  parameter int EPOCH_LEN = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xlat_valid,
  input  logic [$clog2(NAPP)-1:0]  xlat_app,
  input  logic [$clog2(NBANK)-1:0] xlat_bank,
  input  logic [ROWW-1:0]          xlat_row,
  output logic                     xlat_ready,
  input  logic                     data_valid,
  input  logic [$clog2(NAPP)-1:0]  data_app,
  input  logic [$clog2(NBANK)-1:0] data_bank,
  input  logic [ROWW-1:0]          data_row,
  output logic                     data_ready,
  input  logic                     walk_start_valid,
  input  logic [$clog2(NAPP)-1:0]  walk_start_app,
  input  logic                     walk_end_valid,
  input  logic [$clog2(NAPP)-1:0]  walk_end_app,
  input  logic                     merge_valid,
  input  logic [$clog2(NAPP)-1:0]  merge_app,
  input  logic [CNTW-1:0]          merge_warps,
  input  logic                     issue_ready,
  output logic                     issue_valid,
  output logic [1:0]               issue_cls,
  output logic [$clog2(NAPP)-1:0]  issue_app,
  output logic [$clog2(NBANK)-1:0] issue_bank,
  output logic [ROWW-1:0]          issue_row
);
  localparam int AW  = $clog2(NAPP);
  localparam int BW  = $clog2(NBANK);
  localparam int TPW = $clog2(TQD);
  localparam int DPW = $clog2(DQD);
  localparam int TCW = $clog2(TQD + 1);
  localparam int DCW = $clog2(DQD + 1);
  localparam int QW  = $clog2(QMAX + 1);
  localparam int PW  = 2 * CNTW;
  localparam int SW  = PW + AW;
  localparam int NW  = QW + PW;
  localparam int DBW = $clog2(NW);
  localparam int EW  = $clog2(EPOCH_LEN);
  localparam int EWD = AW + BW + ROWW;
  localparam logic [1:0] CL_XL = 2'd0, CL_FV = 2'd1, CL_NM = 2'd2;

  logic [ROWW-1:0]  open_row [NBANK];
  logic [NBANK-1:0] open_vld;
  logic [EWD-1:0]   tq [TQD];
  logic [TPW-1:0]   tq_rd, tq_wr;
  logic [TCW-1:0]   tq_cnt;
  logic [EWD-1:0]   dq [2][DQD];
  logic [DCW-1:0]   dq_cnt [2];
  logic [DPW-1:0]   dq_sel [2];
  logic [1:0]       dq_push, dq_pop;
  logic [QW-1:0]    quota [NAPP];
  logic [AW-1:0]    cur, nxt;
  logic [QW-1:0]    fav_cnt;
  logic             fav_on, to_fav, tq_push, tq_pop, fire, adv;
  logic [EWD-1:0]   head;

  // ---------------- enqueue and class backpressure ----------------
  assign fav_on     = quota[cur] != '0;
  assign to_fav     = fav_on && (data_app == cur);
  assign xlat_ready = tq_cnt != TCW'(TQD);
  assign data_ready = to_fav ? (dq_cnt[0] != DCW'(DQD)) : (dq_cnt[1] != DCW'(DQD));
  assign tq_push    = xlat_valid && xlat_ready;
  assign dq_push    = {data_valid && data_ready && !to_fav, data_valid && data_ready && to_fav};

  // ---------------- row-hit-first selection ----------------
  always_comb begin
    for (int q = 0; q < 2; q++) begin
      dq_sel[q] = '0;
      for (int i = DQD - 1; i >= 0; i--)
        if (i < int'(dq_cnt[q]) && open_vld[dq[q][i][ROWW +: BW]] &&
            open_row[dq[q][i][ROWW +: BW]] == dq[q][i][ROWW-1:0])
          dq_sel[q] = DPW'(i);
    end
  end

  // ---------------- strict priority issue ----------------
  assign issue_valid = (tq_cnt != '0) || (dq_cnt[0] != '0) || (dq_cnt[1] != '0);
  always_comb begin
    if (tq_cnt != '0) begin
      head = tq[tq_rd]; issue_cls = CL_XL;
    end else if (dq_cnt[0] != '0) begin
      head = dq[0][dq_sel[0]]; issue_cls = CL_FV;
    end else begin
      head = dq[1][dq_sel[1]]; issue_cls = CL_NM;
    end
  end
  assign {issue_app, issue_bank, issue_row} = head;
  assign fire      = issue_valid && issue_ready;
  assign tq_pop    = fire && (tq_cnt != '0);
  assign dq_pop[0] = fire && (tq_cnt == '0) && (dq_cnt[0] != '0);
  assign dq_pop[1] = fire && (tq_cnt == '0) && (dq_cnt[0] == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) open_vld <= '0;
    else if (fire) begin
      open_vld[issue_bank] <= 1'b1;
      open_row[issue_bank] <= issue_row;
    end

  // ---------------- translation FIFO ----------------
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tq_rd <= '0; tq_wr <= '0; tq_cnt <= '0;
    end else begin
      if (tq_push) begin
        tq[tq_wr] <= {xlat_app, xlat_bank, xlat_row};
        tq_wr <= (tq_wr == TPW'(TQD - 1)) ? '0 : tq_wr + 1'b1;
      end
      if (tq_pop) tq_rd <= (tq_rd == TPW'(TQD - 1)) ? '0 : tq_rd + 1'b1;
      tq_cnt <= tq_cnt + TCW'(tq_push) - TCW'(tq_pop);
    end

  // ---------------- collapsing data queues, oldest at 0 ----------------
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dq_cnt[0] <= '0; dq_cnt[1] <= '0;
    end else begin
      for (int q = 0; q < 2; q++) begin
        for (int i = 0; i < DQD - 1; i++)
          if (dq_pop[q] && i >= int'(dq_sel[q])) dq[q][i] <= dq[q][i+1];
        if (dq_push[q])
          dq[q][DPW'(dq_cnt[q] - DCW'(dq_pop[q]))] <= {data_app, data_bank, data_row};
        dq_cnt[q] <= dq_cnt[q] + DCW'(dq_push[q]) - DCW'(dq_pop[q]);
      end
    end

  // ---------------- per-application metrics and epoch ----------------
  logic [CNTW-1:0] walks [NAPP];
  logic [CNTW-1:0] stall [NAPP];
  logic [EW-1:0]   epoch_cnt;
  logic            epoch_end;
  logic [PW-1:0]   prod_now [NAPP];
  logic [SW-1:0]   sum_now;

  assign epoch_end = epoch_cnt == EW'(EPOCH_LEN - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) epoch_cnt <= '0;
    else        epoch_cnt <= epoch_end ? '0 : epoch_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int a = 0; a < NAPP; a++) begin walks[a] <= '0; stall[a] <= '0; end
    end else if (epoch_end) begin
      for (int a = 0; a < NAPP; a++) begin walks[a] <= '0; stall[a] <= '0; end
    end else begin
      for (int a = 0; a < NAPP; a++) begin
        if (walk_start_valid && walk_start_app == AW'(a) &&
            !(walk_end_valid && walk_end_app == AW'(a)) && walks[a] != '1)
          walks[a] <= walks[a] + 1'b1;
        else if (walk_end_valid && walk_end_app == AW'(a) &&
                 !(walk_start_valid && walk_start_app == AW'(a)) && walks[a] != '0)
          walks[a] <= walks[a] - 1'b1;
        if (merge_valid && merge_app == AW'(a) && merge_warps > stall[a])
          stall[a] <= merge_warps;
      end
    end

  always_comb begin
    sum_now = '0;
    for (int a = 0; a < NAPP; a++) begin
      prod_now[a] = PW'(walks[a]) * PW'(stall[a]);
      sum_now = sum_now + SW'(prod_now[a]);
    end
  end

  // ---------------- sequential quota divider ----------------
  logic            div_busy;
  logic [AW-1:0]   div_idx;
  logic [DBW-1:0]  div_bit;
  logic [SW-1:0]   rem, rem_nx, sum_snap;
  logic [NW-1:0]   quo, quo_nx, dvd;
  logic [PW-1:0]   prod_snap [NAPP];
  logic [SW:0]     rem_sh;
  logic            ge;

  assign dvd    = NW'(prod_snap[div_idx]) * NW'(QMAX);
  assign rem_sh = {rem, dvd[div_bit]};
  assign ge     = (sum_snap != '0) && (rem_sh >= {1'b0, sum_snap});
  assign rem_nx = ge ? SW'(rem_sh - {1'b0, sum_snap}) : SW'(rem_sh);
  assign quo_nx = {quo[NW-2:0], ge};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_busy <= 1'b0; div_idx <= '0; div_bit <= '0;
      rem <= '0; quo <= '0; sum_snap <= '0;
      for (int a = 0; a < NAPP; a++) begin quota[a] <= '0; prod_snap[a] <= '0; end
    end else if (epoch_end && !div_busy) begin
      div_busy <= 1'b1; div_idx <= '0; div_bit <= DBW'(NW - 1);
      rem <= '0; quo <= '0; sum_snap <= sum_now;
      for (int a = 0; a < NAPP; a++) prod_snap[a] <= prod_now[a];
    end else if (div_busy) begin
      rem <= rem_nx; quo <= quo_nx;
      if (div_bit == '0) begin
        quota[div_idx] <= QW'(quo_nx);
        rem <= '0; quo <= '0; div_bit <= DBW'(NW - 1);
        if (div_idx == AW'(NAPP - 1)) div_busy <= 1'b0;
        else div_idx <= div_idx + 1'b1;
      end else div_bit <= div_bit - 1'b1;
    end

  // ---------------- favoured-turn rotation ----------------
  always_comb begin
    nxt = cur;
    for (int k = NAPP; k >= 1; k--)
      if (quota[AW'((int'(cur) + k) % NAPP)] != '0) nxt = AW'((int'(cur) + k) % NAPP);
  end

  assign adv = !fav_on || (dq_push[0] && ((QW+1)'(fav_cnt) + 1'b1 >= {1'b0, quota[cur]}));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur <= '0; fav_cnt <= '0;
    end else if (adv) begin
      cur <= nxt; fav_cnt <= '0;
    end else if (dq_push[0]) fav_cnt <= fav_cnt + 1'b1;

  // ---------------- assertions ----------------
  // R8
  tq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tq_cnt <= TCW'(TQD));

  // R2
  fav_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_cnt[0] != '0 && tq_cnt == '0 && issue_ready && !dq_push[0])
      |=> dq_cnt[0] == $past(dq_cnt[0]) - 1'b1);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> issue_valid);

  // R5
  quota_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && div_bit == '0) |=> quota[$past(div_idx)] <= QW'(QMAX));

  // R7
  walk_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_start_valid && !(walk_end_valid && walk_end_app == walk_start_app) &&
     !epoch_end && walks[walk_start_app] != '1)
      |=> walks[$past(walk_start_app)] == $past(walks[walk_start_app]) + 1'b1);
endmodule

// File: tb/tprio_dram_arb_bench.sv
`timescale 1ns/1ps
module tprio_dram_arb_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xlat_valid = 0, data_valid = 0, issue_ready = 1;
  logic [1:0] xlat_app = 0, xlat_bank = 0, data_app = 0, data_bank = 0;
  logic [7:0] xlat_row = 0, data_row = 0;
  logic walk_start_valid = 0, walk_end_valid = 0, merge_valid = 0;
  logic [1:0] walk_start_app = 0, walk_end_app = 0, merge_app = 0;
  logic [5:0] merge_warps = 0;
  logic xlat_ready, data_ready, issue_valid;
  logic [1:0] issue_cls, issue_app, issue_bank;
  logic [7:0] issue_row;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  tprio_dram_arb u_tprio_dram_arb (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_issue(input string tag, input int cls, input int row);
    int act, exp;
    act = {issue_valid, issue_cls, issue_row};
    exp = {1'b1, 2'(cls), 8'(row)};
    chk(act == exp, tag, act, exp);
  endtask

  task automatic expect_idle(input string tag);
    chk(issue_valid == 1'b0, tag, issue_valid, 0);
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic set_x(input bit v, input int bank, input int row);
    xlat_valid = v; xlat_app = 2'd0; xlat_bank = 2'(bank); xlat_row = 8'(row);
  endtask

  task automatic set_d(input bit v, input int app, input int bank, input int row);
    data_valid = v; data_app = 2'(app); data_bank = 2'(bank); data_row = 8'(row);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
  endtask

  task automatic t_reset;
    #1;
    chk(issue_valid == 0, "R9 issue_valid after reset", issue_valid, 0);
    chk(xlat_ready == 1, "R9 xlat_ready after reset", xlat_ready, 1);
    chk(data_ready == 1, "R9 data_ready after reset", data_ready, 1);
  endtask

  task automatic t_metrics;
    walk_start_valid = 1; walk_start_app = 0; merge_valid = 1; merge_app = 0; merge_warps = 3; step();
    merge_warps = 4; step();
    merge_app = 1; merge_warps = 8; step();
    walk_start_app = 1; walk_end_valid = 1; walk_end_app = 0; merge_warps = 2; step();
    walk_start_valid = 0; walk_end_valid = 0; merge_valid = 0; step();
  endtask

  task automatic t_frfcfs;
    set_x(1, 0, 5); set_d(1, 2, 1, 3); step();
    expect_issue("R2 translation before normal", 0, 5);
    set_x(1, 1, 7); set_d(1, 2, 1, 7); step();
    expect_issue("R2 second translation first", 0, 7);
    set_x(1, 2, 1); set_d(1, 3, 1, 3); step();
    expect_issue("R2 third translation first", 0, 1);
    set_x(0, 0, 0); set_d(0, 0, 0, 0); step();
    expect_issue("R3 row hit beats older", 2, 7);
    step();
    expect_issue("R3 oldest when no hit", 2, 3);
    step();
    expect_issue("R3 last normal", 2, 3);
    step();
    expect_idle("R3 queues empty");
    set_d(1, 0, 0, 44); step();
    set_d(0, 0, 0, 0);
    expect_issue("R6 zero quota sends app0 to normal", 2, 44);
    step();
  endtask

  task automatic t_xlat_order;
    issue_ready = 0;
    set_x(1, 0, 1); step();
    set_x(1, 0, 5); step();
    set_x(1, 0, 2); step();
    set_x(1, 0, 5); step();
    set_x(0, 0, 0); data_app = 3; #1;
    chk(xlat_ready == 0, "R8 xlat_ready low when full", xlat_ready, 0);
    chk(data_ready == 1, "R8 data class unaffected", data_ready, 1);
    expect_issue("R10 head offered while stalled", 0, 1);
    step();
    expect_issue("R10 head held while stalled", 0, 1);
    issue_ready = 1; #1;
    expect_issue("R1 first in order", 0, 1);
    step();
    expect_issue("R1 second in order", 0, 5);
    step();
    expect_issue("R1 miss not overtaken by later hit", 0, 2);
    step();
    expect_issue("R1 fourth in order", 0, 5);
    step();
    expect_idle("R1 fifo drained");
  endtask

  task automatic t_class_bp;
    issue_ready = 0;
    for (int i = 0; i < 4; i++) begin set_d(1, 2, 3, 10 + i); step(); end
    set_d(0, 2, 3, 0); #1;
    chk(data_ready == 0, "R8 normal full stalls app2", data_ready, 0);
    data_app = 0; #1;
    chk(data_ready == 1, "R8 favoured class still open", data_ready, 1);
    chk(xlat_ready == 1, "R8 translation class still open", xlat_ready, 1);
    set_d(1, 0, 2, 9); step();
    set_d(0, 0, 0, 0);
    expect_issue("R2 favoured beats older normal", 1, 9);
    issue_ready = 1; #1;
    expect_issue("R4 favoured queue source", 1, 9);
    for (int i = 0; i < 4; i++) begin
      step();
      expect_issue("R3 normal drains oldest first", 2, 10 + i);
    end
    step();
    expect_idle("R2 all drained");
  endtask

  task automatic push_chk(input int app, input int row, input int cls, input string tag);
    set_d(1, app, 0, row); step();
    set_d(0, 0, 0, 0);
    expect_issue(tag, cls, row);
  endtask

  task automatic t_rotation;
    push_chk(0, 20, 1, "R5 app0 turn second");
    push_chk(0, 21, 1, "R5 app0 turn third");
    push_chk(0, 22, 1, "R5 app0 turn fourth");
    push_chk(0, 23, 2, "R5 app0 quota used, normal");
    push_chk(1, 24, 1, "R5 app1 turn first");
    push_chk(1, 25, 1, "R5 app1 turn second");
    push_chk(1, 26, 1, "R5 app1 turn third");
    push_chk(1, 27, 1, "R5 app1 turn fourth");
    push_chk(1, 28, 2, "R5 app1 quota used, normal");
    push_chk(0, 29, 1, "R6 apps 2 and 3 skipped");
    push_chk(2, 30, 2, "R4 non-holder goes normal");
    step();
  endtask

  task automatic t_epoch_clear;
    push_chk(0, 40, 2, "R7 cleared metrics give app0 no turn");
    push_chk(1, 41, 2, "R6 all quotas zero, app1 normal");
    step();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_metrics();
    t_frfcfs();
    t_xlat_order();
    wait (cyc >= 340);
    step();
    t_class_bp();
    t_rotation();
    wait (cyc >= 640);
    step();
    t_epoch_clear();
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 700);
      report();
      $finish;
    end
  end
endmodule